// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Core

This block is a synchronous behavioural model of the control logic inside a small 4096 x 1 dynamic memory. The cells form a square array of 64 rows of 64 bits. One 6-bit address bus carries the row half of an address and then the column half. Three active-low strobes set the timing: a row strobe, a column strobe and a write enable. Data moves one bit at a time through a data input pin and a data output pin. The data output has an output-enable flag that stands in for a high-impedance driver.

All strobes are sampled on a fast system clock, and their edges are found synchronously. A row-strobe fall opens a row: the whole 64-bit row is copied into a row buffer. Column-strobe falls inside that row-strobe cycle then read or replace single bits in the buffer. A row-strobe rise writes the buffer back to the array. The configuration pin `nibble_mode` selects how column-strobe pulses inside one open row pick their columns:

- **Page mode**: each pulse takes a fresh column address from the bus.
- **Nibble mode**: the first pulse takes a column address, and each later pulse steps to the next column inside an aligned group of four.

The block supports two kinds of refresh:

- **Row-strobe-only cycle**: a row cycle with no column activity refreshes the row given on the bus.
- **Column-before-row cycle**: the column strobe falls first and the row strobe falls after it. This refreshes the row named by an internal 6-bit pointer, which then advances by one.

Top module: `mux_dram_core`

## Requirements
- R1: The row address is taken from `addr` when the row strobe falls. The column address is taken from the same pins at a later column-strobe fall in that row cycle. Distinct rows hold distinct data.
- R2: A column-strobe fall with `we_n` high starts a read of bit (row, column). `dout_oe` then goes to 1 and `dout` carries that bit. `dout_oe` returns to 0 after the column strobe rises. `dout` reads 0 whenever `dout_oe` is 0.
- R3: A column-strobe fall with `we_n` low replaces the selected bit in the row buffer with `din`. All other bits of the row are left unchanged, and `dout_oe` stays 0.
- R4: A row-strobe rise writes the row buffer back to the opened row, so written data persists into later row cycles. This holds even when the row strobe rises before the column strobe, which is the usual write ordering.
- R5: With `nibble_mode` = 0 (page mode), every column-strobe fall in one row cycle uses the column address on the bus at that fall.
- R6: With `nibble_mode` = 1, the first column-strobe fall of a row cycle uses the bus address. Each later fall in that cycle keeps column bits [5:2] and adds 1 modulo 4 to bits [1:0]; the bus is ignored for these falls. For example, start 6 gives 6, 7, 4, 5.
- R7: If the column strobe falls while the row strobe is high, the next row-strobe fall is a refresh of row `rfsh_row`. The contents of that row are kept. The pointer increments by 1 at the row-strobe rise, wrapping from 63 to 0.
- R8: A row-strobe cycle with no column-strobe activity rewrites the row on the bus unchanged, and `rfsh_row` does not move.
- R9: After reset, `dout_oe` = 0 and `rfsh_row` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Multiplexed row/column address bus |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write enable, sampled at column-strobe fall |
| din | input | 1 | Write data bit |
| nibble_mode | input | 1 | Static mode select: 0 page mode, 1 nibble mode |
| dout | output | 1 | Read data bit, 0 while not enabled |
| dout_oe | output | 1 | Output-enable flag modelling high impedance when 0 |
| rfsh_row | output | 6 | Current internal refresh row pointer |

## Verification
The hardest situation to reach from the ports is the refresh pointer wrapping from 63 back to 0 while refreshed data stays intact. The bench gets there by running 64 complete column-before-row cycles, and it checks the pointer after the first cycle and after the last. It then reads back a row that the pointer passed over. Nibble stepping is provoked by starting at a column in the middle of a group and driving an unrelated address on the later pulses. This shows that only the group wrap decides the column.

// File: rtl/mux_dram_pkg.sv
package mux_dram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE    = 2'd0,
    CYC_ACCESS  = 2'd1,
    CYC_REFRESH = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/edge_sense.sv
module edge_sense #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_n,
  output logic [W-1:0] lvl_n,
  output logic [W-1:0] prv_n,
  output logic [W-1:0] fall,
  output logic [W-1:0] rise
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_n[i] <= 1'b1;
        prv_n[i] <= 1'b1;
      end else begin
        lvl_n[i] <= sig_n[i];
        prv_n[i] <= lvl_n[i];
      end
    end
    assign fall[i] = prv_n[i] & ~lvl_n[i];
    assign rise[i] = ~prv_n[i] & lvl_n[i];
  end
endmodule

// File: rtl/cell_array.sv
module cell_array #(
  parameter int AW = 6,
  localparam int ROWS = 1 << AW,
  localparam int COLS = 1 << AW
) (
  input  logic            clk,
  input  logic [AW-1:0]   rd_row,
  output logic [COLS-1:0] rd_data,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_row,
  input  logic [COLS-1:0] wr_data
);
  logic [COLS-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= wr_data;
  end

  assign rd_data = mem[rd_row];
endmodule

// File: rtl/col_step.sv
module col_step #(
  parameter int AW      = 6,
  parameter int NIB_LOG = 2
) (
  input  logic          nibble,
  input  logic          seq,
  input  logic [AW-1:0] cur_col,
  input  logic [AW-1:0] pin_col,
  output logic [AW-1:0] next_col
);
  logic [NIB_LOG-1:0] low_inc;
  assign low_inc = cur_col[NIB_LOG-1:0] + 1'b1;

  always_comb begin
    if (nibble && seq) next_col = {cur_col[AW-1:NIB_LOG], low_inc};
    else               next_col = pin_col;
  end
endmodule

// File: rtl/mux_dram_core.sv
module mux_dram_core
  import mux_dram_pkg::*;
#(
  parameter int AW      = 6,
  parameter int NIB_LOG = 2,
  localparam int COLS   = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          din,
  input  logic          nibble_mode,
  output logic          dout,
  output logic          dout_oe,
  output logic [AW-1:0] rfsh_row
);
  logic [AW-1:0] addr_q;
  logic          din_q, we_q;
  logic [1:0]    lvl_n, prv_n, fall, rise;
  logic          ras_fall, ras_rise, cas_fall, cas_rise, ras_hi, cas_prv_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      din_q  <= 1'b0;
      we_q   <= 1'b1;
    end else begin
      addr_q <= addr;
      din_q  <= din;
      we_q   <= we_n;
    end
  end

  edge_sense #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig_n({ras_n, cas_n}),
    .lvl_n(lvl_n), .prv_n(prv_n), .fall(fall), .rise(rise)
  );

  assign ras_fall  = fall[1];
  assign ras_rise  = rise[1];
  assign cas_fall  = fall[0];
  assign cas_rise  = rise[0];
  assign ras_hi    = lvl_n[1];
  assign cas_prv_n = prv_n[0];

  cyc_kind_e       kind;
  logic [AW-1:0]   row_q, col_q, rfsh_ptr, rd_idx, nxt_col;
  logic [COLS-1:0] row_buf, arr_rd;
  logic            cbr_pend, col_valid, dout_q, wb_en, col_access;

  assign rd_idx     = cbr_pend ? rfsh_ptr : addr_q;
  assign wb_en      = ras_rise && (kind != CYC_IDLE);
  assign col_access = cas_fall && (kind == CYC_ACCESS);

  cell_array #(.AW(AW)) u_arr (
    .clk(clk), .rd_row(rd_idx), .rd_data(arr_rd),
    .wr_en(wb_en), .wr_row(row_q), .wr_data(row_buf)
  );

  col_step #(.AW(AW), .NIB_LOG(NIB_LOG)) u_col (
    .nibble(nibble_mode), .seq(col_valid), .cur_col(col_q),
    .pin_col(addr_q), .next_col(nxt_col)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind      <= CYC_IDLE;
      row_q     <= '0;
      col_q     <= '0;
      rfsh_ptr  <= '0;
      row_buf   <= '0;
      cbr_pend  <= 1'b0;
      col_valid <= 1'b0;
      dout_q    <= 1'b0;
      dout_oe   <= 1'b0;
    end else begin
      if (ras_fall) begin
        kind      <= cbr_pend ? CYC_REFRESH : CYC_ACCESS;
        row_q     <= rd_idx;
        row_buf   <= arr_rd;
        cbr_pend  <= 1'b0;
        col_valid <= 1'b0;
      end else if (cas_fall && ras_hi) begin
        cbr_pend <= 1'b1;
      end else if (cas_rise && ras_hi) begin
        cbr_pend <= 1'b0;
      end

      if (col_access) begin
        col_q     <= nxt_col;
        col_valid <= 1'b1;
        if (!we_q) begin
          row_buf[nxt_col] <= din_q;
          dout_oe          <= 1'b0;
        end else begin
          dout_q  <= row_buf[nxt_col];
          dout_oe <= 1'b1;
        end
      end

      if (cas_rise) dout_oe <= 1'b0;

      if (ras_rise) begin
        kind <= CYC_IDLE;
        if (kind == CYC_REFRESH) rfsh_ptr <= rfsh_ptr + 1'b1;
      end
    end
  end

  assign dout     = dout_q & dout_oe;
  assign rfsh_row = rfsh_ptr;

  // Output enable only while the sampled column strobe is low (R2)
  assert_oe_needs_cas_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> !cas_prv_n);

  assert_write_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_access && !we_q) |=> !dout_oe);

  assert_page_col_from_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_access && !nibble_mode) |=> col_q == $past(addr_q));

  assert_nibble_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_access && nibble_mode && col_valid) |=>
      (col_q[NIB_LOG-1:0] == NIB_LOG'($past(col_q[NIB_LOG-1:0]) + 1'b1)) &&
      (col_q[AW-1:NIB_LOG] == $past(col_q[AW-1:NIB_LOG])));

  assert_ptr_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_rise && kind == CYC_REFRESH) |=> rfsh_ptr == AW'($past(rfsh_ptr) + 1'b1));

  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ras_rise && kind == CYC_REFRESH) |=> $stable(rfsh_ptr));
endmodule

// File: tb/tb_mux_dram_core.sv
`timescale 1ns/1ps
module tb_mux_dram_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0, nibble_mode = 1'b0;
  logic       dout, dout_oe;
  logic [5:0] rfsh_row;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;
  logic [7:0] pat = 8'b1011_0010;

  always #2 clk = ~clk;

  mux_dram_core dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .din(din), .nibble_mode(nibble_mode),
    .dout(dout), .dout_oe(dout_oe), .rfsh_row(rfsh_row)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    @(negedge clk);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ras_open(input logic [5:0] row);
    addr = row; cyc(1); ras_n = 0; cyc(3);
  endtask

  task automatic ras_close();
    ras_n = 1; cyc(3);
  endtask

  task automatic cas_read(input logic [5:0] col, input logic exp, input string tag);
    addr = col; we_n = 1; cyc(1); cas_n = 0; cyc(3);
    chk({tag, " oe"}, {7'd0, dout_oe}, 8'd1);
    chk({tag, " data"}, {7'd0, dout}, {7'd0, exp});
    cas_n = 1; cyc(3);
    chk({tag, " oe off"}, {7'd0, dout_oe}, 8'd0);
  endtask

  task automatic cas_write(input logic [5:0] col, input logic b);
    addr = col; we_n = 0; din = b; cyc(1); cas_n = 0; cyc(3);
    chk("R3 no drive on write", {7'd0, dout_oe}, 8'd0);
    cas_n = 1; cyc(2); we_n = 1;
  endtask

  task automatic cbr_cycle();
    cas_n = 0; cyc(3); ras_n = 0; cyc(3); cas_n = 1; cyc(2); ras_n = 1; cyc(3);
  endtask

  task automatic t_reset();
    chk("R9 oe after reset", {7'd0, dout_oe}, 8'd0);
    chk("R9 pointer after reset", {2'd0, rfsh_row}, 8'd0);
    chk("R2 dout low when idle", {7'd0, dout}, 8'd0);
  endtask

  task automatic t_basic();
    ras_open(6'd5); cas_write(6'd9, 1'b1); cas_write(6'd10, 1'b0); ras_close();
    ras_open(6'd6); cas_write(6'd9, 1'b0); ras_close();
    ras_open(6'd5);
    cas_read(6'd9, 1'b1, "R1 R4 row5 col9");
    cas_read(6'd10, 1'b0, "R3 row5 col10");
    ras_close();
    ras_open(6'd5); cas_write(6'd10, 1'b1); ras_close();
    ras_open(6'd5);
    cas_read(6'd9, 1'b1, "R3 neighbour kept");
    cas_read(6'd10, 1'b1, "R3 bit replaced");
    ras_close();
    ras_open(6'd6); cas_read(6'd9, 1'b0, "R1 row6 separate"); ras_close();
  endtask

  task automatic t_page();
    ras_open(6'd20);
    for (int i = 0; i < 8; i++) cas_write(6'(i), pat[i]);
    ras_close();
    ras_open(6'd20);
    for (int i = 7; i >= 0; i--) cas_read(6'(i), pat[i], "R5 page read");
    ras_close();
  endtask

  task automatic t_late_cas_rise();
    ras_open(6'd30);
    addr = 6'd3; we_n = 0; din = 1; cyc(1); cas_n = 0; cyc(3);
    ras_n = 1; cyc(3); cas_n = 1; cyc(2); we_n = 1; din = 0; cyc(2);
    ras_open(6'd30); cas_read(6'd3, 1'b1, "R4 row strobe rises first"); ras_close();
  endtask

  task automatic t_nibble();
    nibble_mode = 1; cyc(2);
    ras_open(6'd20);
    cas_read(6'd6, pat[6], "R6 nibble first");
    cas_read(6'd0, pat[7], "R6 nibble step 7");
    cas_read(6'd0, pat[4], "R6 nibble wrap 4");
    cas_read(6'd0, pat[5], "R6 nibble step 5");
    ras_close();
    nibble_mode = 0; cyc(2);
  endtask

  task automatic t_ras_only();
    ras_open(6'd20); ras_close();
    chk("R8 pointer unmoved", {2'd0, rfsh_row}, 8'd0);
    ras_open(6'd20);
    cas_read(6'd1, pat[1], "R8 row kept col1");
    cas_read(6'd7, pat[7], "R8 row kept col7");
    ras_close();
  endtask

  task automatic t_cbr();
    cbr_cycle();
    chk("R7 pointer step", {2'd0, rfsh_row}, 8'd1);
    chk("R7 no drive in refresh", {7'd0, dout_oe}, 8'd0);
    for (int i = 0; i < 63; i++) cbr_cycle();
    chk("R7 pointer wrap", {2'd0, rfsh_row}, 8'd0);
    ras_open(6'd20);
    cas_read(6'd4, pat[4], "R7 data kept col4");
    cas_read(6'd5, pat[5], "R7 data kept col5");
    ras_close();
    ras_open(6'd5); cas_read(6'd9, 1'b1, "R7 row5 kept"); ras_close();
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    t_reset();
    t_basic();
    t_page();
    t_late_cas_rise();
    t_nibble();
    t_ras_only();
    t_cbr();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule